// File: doc/BRIEF.md
# Parity Error Capture Status Register

This block sits beside an external bus controller and keeps a record of parity errors that the controller reports. Two kinds of error arrive as single-cycle pulses, each with the word address of the failing transfer. One kind comes from inbound writes. The other comes from outbound reads, and it also carries the index of the chip select that was being accessed.

An inbound error counts only while a global inbound parity enable is high. An outbound error counts only when the enable bit for its chip select is high. Each error that counts sets its own sticky flag. The first error that counts also freezes its word address into a read-only field.

Software reads a 32-bit status word through a simple single-cycle register port. It acknowledges errors by writing ones to the flag bits. The OR of the two flags drives a single interrupt line.

Top module: `perr_status_reg`

## Requirements
- R1: After a synchronous reset the status word reads 0x00000000 and the interrupt line is low.
- R2: An inbound error pulse sets bit 1 of the status word only when the global inbound enable is high in the same cycle. With the enable low, bit 1 and the address field stay unchanged.
- R3: An outbound error pulse sets bit 0 only when the enable bit selected by its chip-select index is high. Otherwise bit 0 and the address field stay unchanged.
- R4: A write with select and write enable high clears each flag bit (bit 1 or bit 0) whose write-data bit is 1. A flag bit whose write-data bit is 0 is left unchanged.
- R5: Bits 31:2 hold the captured word address and are read-only. Writes never change them.
- R6: While either flag is set, the address field is locked and keeps the address of the first counted error.
- R7: Once both flags are clear, the field is unlocked and keeps its old value until the next counted error replaces it.
- R8: The interrupt output equals bit 1 OR bit 0 of the status word in every cycle.
- R9: If a flag is cleared in one cycle and a counted error of the same type arrives in a later cycle, the flag is set again.
- R10: If a clear of a flag and a counted error of the same type fall in the same cycle, the clear wins and the flag stays 0.
- R11: When the field is unlocked and counted errors of both types arrive in the same cycle, the inbound address is captured.
- R12: Read data in a write cycle shows the register contents from before that write.
- R13: A counted error that arrives while the field is locked still sets its own flag, but it does not change the stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_perr | input | 1 | Inbound write parity error pulse |
| in_waddr | input | 30 | Word address of the inbound error |
| in_par_en | input | 1 | Global inbound parity enable |
| out_perr | input | 1 | Outbound read parity error pulse |
| out_waddr | input | 30 | Word address of the outbound error |
| out_cs | input | CS_W | Chip-select index of the outbound error |
| cs_par_en | input | NUM_CS | Per-chip-select outbound parity enables |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write enable for the access |
| reg_wdata | input | 32 | Write data; bits 1 and 0 are the clear mask |
| reg_rdata | output | 32 | Status word: address[31:2], inbound flag[1], outbound flag[0] |
| irq | output | 1 | Combined parity error interrupt |

## Verification
Each error type is pulsed with its enable low and then high. This shows that qualification is the only thing that lets a flag rise. Errors that arrive while the field is locked, and a pair of errors that arrive together while it is unlocked, show the difference between capture and lock, and show which source has priority.

Clears are tried four ways: with a zero mask, with an all-ones mask on the address bits, one cycle before a new error, and in the same cycle as a new error. Together these separate write-one-to-clear from a plain write and expose the lost-error race. Read data is sampled during a write to confirm that the old contents are returned.

// File: rtl/perr_pkg.sv
package perr_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned WADDR_W = REG_W - 2;
  localparam int unsigned NFLAG   = 2;
  localparam int unsigned IDX_OUT = 0;
  localparam int unsigned IDX_IN  = 1;

  typedef struct packed {
    logic [WADDR_W-1:0] waddr;
    logic               in_err;
    logic               out_err;
  } status_t;
endpackage

// File: rtl/perr_flag.sv
module perr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/perr_addr_latch.sv
module perr_addr_latch #(
  parameter int unsigned W = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         lock_i,
  input  logic         in_hit_i,
  input  logic [W-1:0] in_addr_i,
  input  logic         out_hit_i,
  input  logic [W-1:0] out_addr_i,
  output logic [W-1:0] addr_o
);
  logic         take;
  logic [W-1:0] pick;

  always_comb begin
    take = !lock_i && (in_hit_i || out_hit_i);
    pick = in_hit_i ? in_addr_i : out_addr_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       addr_o <= '0;
    else if (take) addr_o <= pick;
  end
endmodule

// File: rtl/perr_status_reg.sv
module perr_status_reg
  import perr_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  localparam int unsigned CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_perr,
  input  logic [WADDR_W-1:0] in_waddr,
  input  logic               in_par_en,
  input  logic               out_perr,
  input  logic [WADDR_W-1:0] out_waddr,
  input  logic [CS_W-1:0]    out_cs,
  input  logic [NUM_CS-1:0]  cs_par_en,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq
);
  logic             wr_stb;
  logic             in_hit, out_hit;
  logic [NFLAG-1:0] set_vec, clr_vec, flag_q;
  logic [WADDR_W-1:0] addr_q;
  status_t          stat;
  logic             unused_wdata;

  always_comb begin
    wr_stb  = reg_sel && reg_wr;
    in_hit  = in_perr && in_par_en;
    out_hit = out_perr && (int'(out_cs) < NUM_CS) && cs_par_en[out_cs];
    set_vec          = '0;
    set_vec[IDX_IN]  = in_hit;
    set_vec[IDX_OUT] = out_hit;
    clr_vec = wr_stb ? reg_wdata[NFLAG-1:0] : '0;
  end

  assign unused_wdata = ^reg_wdata[REG_W-1:NFLAG];

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    perr_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_vec[g]),
      .clr_i  (clr_vec[g]),
      .flag_o (flag_q[g])
    );
  end

  perr_addr_latch #(.W(WADDR_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .lock_i     (|flag_q),
    .in_hit_i   (in_hit),
    .in_addr_i  (in_waddr),
    .out_hit_i  (out_hit),
    .out_addr_i (out_waddr),
    .addr_o     (addr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |((flag_q | set_vec) & ~clr_vec);
  end

  always_comb begin
    stat.waddr   = addr_q;
    stat.in_err  = flag_q[IDX_IN];
    stat.out_err = flag_q[IDX_OUT];
    reg_rdata    = stat;
  end
endmodule

// File: rtl/perr_status_sva.sv
module perr_status_sva (
  input logic        clk,
  input logic        rst,
  input logic        in_perr,
  input logic        in_par_en,
  input logic        out_perr,
  input logic        reg_sel,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        irq
);
  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (rst)
    irq == (reg_rdata[1] | reg_rdata[0])); // R8

  AST_IN_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(reg_rdata[1]) |-> $past(in_perr && in_par_en)); // R2

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && reg_wr && reg_wdata[1]) |=> !reg_rdata[1]); // R10

  AST_ADDR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata[1] || reg_rdata[0]) |=> $stable(reg_rdata[31:2])); // R6

  AST_ADDR_RDONLY: assert property (@(posedge clk) disable iff (rst)
    (!(in_perr && in_par_en) && !out_perr) |=> $stable(reg_rdata[31:2])); // R5
endmodule

bind perr_status_reg perr_status_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .in_perr   (in_perr),
  .in_par_en (in_par_en),
  .out_perr  (out_perr),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq)
);

// File: tb/test_perr_status_reg.sv
`timescale 1ns/1ps
module test_perr_status_reg;
  localparam int NUM_CS = 8;
  localparam int CS_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_perr = 0, in_par_en = 0, out_perr = 0;
  logic [29:0] in_waddr = '0, out_waddr = '0;
  logic [CS_W-1:0] out_cs = '0;
  logic [NUM_CS-1:0] cs_par_en = '0;
  logic reg_sel = 0, reg_wr = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  perr_status_reg #(.NUM_CS(NUM_CS)) i_perr_status_reg (
    .clk(clk), .rst(rst),
    .in_perr(in_perr), .in_waddr(in_waddr), .in_par_en(in_par_en),
    .out_perr(out_perr), .out_waddr(out_waddr), .out_cs(out_cs),
    .cs_par_en(cs_par_en),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic pulse_in(input logic [31:0] a);
    @(negedge clk); in_perr = 1; in_waddr = a[31:2];
    @(negedge clk); in_perr = 0;
  endtask

  task automatic pulse_out(input logic [31:0] a, input int cs);
    @(negedge clk); out_perr = 1; out_waddr = a[31:2]; out_cs = CS_W'(cs);
    @(negedge clk); out_perr = 0;
  endtask

  task automatic wr_reg(input logic [31:0] d, output logic [31:0] seen);
    @(negedge clk); reg_sel = 1; reg_wr = 1; reg_wdata = d;
    #1 seen = reg_rdata;
    @(negedge clk); reg_sel = 0; reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic t_reset;
    chk("R1 status", reg_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_inbound_and_lock;
    logic [31:0] s;
    in_par_en = 0;
    pulse_in(32'h0abc_0010);
    chk("R2 disabled inbound", reg_rdata, 32'h0);
    in_par_en = 1;
    pulse_in(32'h1000_0010);
    chk("R2 inbound set", reg_rdata, 32'h1000_0012);
    chk("R8 irq high", {31'b0, irq}, 32'h1);
    pulse_in(32'h2222_2220);
    chk("R13 locked inbound", reg_rdata, 32'h1000_0012);
    cs_par_en = 8'b0000_0100;
    pulse_out(32'h2468_0000, 2);
    chk("R13 locked outbound", reg_rdata, 32'h1000_0013);
    wr_reg(32'hffff_fffc, s);
    chk("R12 read during write", s, 32'h1000_0013);
    chk("R5 addr read-only / R4 zero mask", reg_rdata, 32'h1000_0013);
    wr_reg(32'h0000_0002, s);
    chk("R4 clear inbound only", reg_rdata, 32'h1000_0011);
    wr_reg(32'h0000_0001, s);
    chk("R7 addr kept after unlock", reg_rdata, 32'h1000_0010);
    chk("R8 irq low", {31'b0, irq}, 32'h0);
    pulse_out(32'h3333_3334, 2);
    chk("R7 recapture after unlock", reg_rdata, 32'h3333_3335);
  endtask

  task automatic t_outbound_enable;
    logic [31:0] s;
    wr_reg(32'h0000_0003, s);
    pulse_out(32'h7777_7770, 5);
    chk("R3 disabled chip select", reg_rdata, 32'h3333_3334);
    chk("R8 irq stays low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] s;
    pulse_out(32'h4444_4440, 2);
    chk("R3 enabled chip select", reg_rdata, 32'h4444_4441);
    wr_reg(32'h0000_0001, s);
    pulse_out(32'h4888_8880, 2);
    chk("R9 clear then error", reg_rdata, 32'h4888_8881);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_wdata = 32'h1;
    out_perr = 1; out_waddr = 30'h1333_3330; out_cs = 3'd2;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; reg_wdata = '0; out_perr = 0;
    chk("R10 same-cycle clear loses error", reg_rdata, 32'h4888_8880);
    chk("R10 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_simultaneous;
    @(negedge clk);
    in_perr = 1; in_waddr = 30'h1555_5555;
    out_perr = 1; out_waddr = 30'h1999_999a; out_cs = 3'd2;
    @(negedge clk);
    in_perr = 0; out_perr = 0;
    chk("R11 inbound address wins", reg_rdata, 32'h5555_5557);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_inbound_and_lock();
    t_outbound_enable();
    t_race();
    t_simultaneous();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule